// File: doc/BRIEF.md
# Multiplexed Address Capture Unit

This unit is the bus front end of a memory device whose address and data share one 16-bit pin bus. It samples the shared bus, a set of dedicated upper-address pins, an address-valid strobe and the output-enable pin on the system clock. From them it builds the full word address that it hands to the memory core. A one-cycle valid pulse marks each new address.

The unit has two modes, chosen by one bit of a volatile configuration register. After reset it is in the default multiplexed mode: every strobe latches the low 16 address bits from the shared bus and the upper bits from the dedicated pins. When the enable bit is set, the unit moves to an all-address-on-data-pins mode. In that mode a strobe with output-enable low loads the upper address bits from the shared bus into a holding register. A strobe with output-enable high supplies the low 16 bits and produces the assembled address. The held upper bits persist, so a run of accesses inside one 64K-word region needs only the low-address phase. The same capture path serves both asynchronous and synchronous read and write cycles, because burst sequencing and data timing are handled elsewhere.

Top module: `addr_capture_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `addr_out` is 0, `addr_valid` is 0 and `mode_o` is 0 (default multiplexed mode).
- R2: A configuration write stores `cfg_wdata` into `cfg_word`, and `mode_o` takes bit 4 of the written word from the next cycle. Bit 4 = 1 selects the all-address-on-data-pins mode, and the other bits do not affect the mode.
- R3: In default mode, a strobe gives `addr_out = {hi_pins, ad_bus}` with `addr_valid` = 1 in the next cycle, whatever the level of `oe_n`.
- R4: A configuration write that changes bit 4 from 0 to 1 clears the held upper address bits to zero.
- R5: In enabled mode, a strobe with `oe_n` = 0 loads `ad_bus[UPPER_W-1:0]` as the held upper bits. It leaves `addr_out` unchanged and `addr_valid` at 0.
- R6: In enabled mode, a strobe with `oe_n` = 1 gives `addr_out = {held upper, ad_bus}` with `addr_valid` = 1 in the next cycle.
- R7: In enabled mode, the held upper bits persist across any number of low-address strobes, and `hi_pins` has no effect on `addr_out`.
- R8: After bit 4 is cleared, the next strobe takes its upper bits from `hi_pins` again.
- R9: In a cycle without a strobe, `addr_valid` is 0 in the next cycle and `addr_out` keeps its value.
- R10: A strobe in the same cycle as a configuration write is decoded with the mode that was in force before the write.
- R11: Writing bit 4 = 1 while the mode is already enabled leaves the held upper bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration word to write; bit 4 is the mode enable |
| adv | input | 1 | Address-valid strobe, active high, sampled each clock |
| oe_n | input | 1 | Output-enable level; selects upper or low phase in enabled mode |
| ad_bus | input | 16 | Shared address/data bus |
| hi_pins | input | UPPER_W | Dedicated upper address pins used in default mode |
| addr_out | output | 16+UPPER_W | Assembled address to the memory core |
| addr_valid | output | 1 | One-cycle pulse marking a new `addr_out` |
| mode_o | output | 1 | Current mode, 1 = all-address-on-data-pins |
| cfg_word | output | 16 | Stored configuration word, feeding neighbouring logic |

## Verification
In default mode the unit is driven with strobes at both output-enable levels. This shows that the pins and not the held register feed the upper bits, and that output-enable is ignored there. In enabled mode it sees upper-then-low sequences, repeated low-only strobes while the pins change, and idle gaps. These separate persistence of the held bits from re-capture and show that the pins are ignored. Configuration writes are placed on their own, on top of a strobe, as repeated enables and as an enable following a non-zero capture. This shows the mode decode order, the zeroing taken only on the 0-to-1 edge, and the return to the pins.

// File: rtl/acu_pkg.sv
`timescale 1ns/1ps
package acu_pkg;
  localparam int LOW_W  = 16;
  localparam int CFG_W  = 16;
  localparam int EN_BIT = 4;

  typedef enum logic {
    MODE_MUX     = 1'b0,
    MODE_ALLDATA = 1'b1
  } mode_e;
endpackage

// File: rtl/acu_cfg_reg.sv
`timescale 1ns/1ps
module acu_cfg_reg
  import acu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] word_q,
  output mode_e            mode,
  output logic             en_rise
);
  // A 0-to-1 change of the enable bit, taken in the write cycle.
  assign en_rise = wr && wdata[EN_BIT] && (mode == MODE_MUX);
  assign mode    = word_q[EN_BIT] ? MODE_ALLDATA : MODE_MUX;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr) begin
      word_q <= wdata;
    end
  end

  AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mode_o_bit(mode) == $past(wdata[EN_BIT]))); // R2

  function automatic logic mode_o_bit(mode_e m);
    return (m == MODE_ALLDATA);
  endfunction
endmodule

// File: rtl/acu_upper_latch.sv
`timescale 1ns/1ps
module acu_upper_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (cap) begin
      q <= d;
    end
  end

  AST_ZERO_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R4
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !cap) |=> $stable(q)); // R7
endmodule

// File: rtl/acu_addr_assemble.sv
`timescale 1ns/1ps
module acu_addr_assemble
  import acu_pkg::*;
#(
  parameter int UPPER_W = 8,
  localparam int ADDR_W = LOW_W + UPPER_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               oe_n,
  input  mode_e              mode,
  input  logic [LOW_W-1:0]   ad,
  input  logic [UPPER_W-1:0] hi,
  input  logic [UPPER_W-1:0] upper_q,
  output logic               upper_cap,
  output logic [ADDR_W-1:0]  addr_out,
  output logic               addr_valid
);
  assign upper_cap = adv && (mode == MODE_ALLDATA) && !oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (adv) begin
        if (mode == MODE_MUX) begin
          addr_out   <= {hi, ad};
          addr_valid <= 1'b1;
        end else if (oe_n) begin
          addr_out   <= {upper_q, ad};
          addr_valid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !addr_valid); // R9
  AST_ADDR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(addr_out)); // R9
  AST_UPPER_PHASE_SILENT: assert property (@(posedge clk) disable iff (rst)
    upper_cap |=> (!addr_valid && $stable(addr_out))); // R5
  AST_DEFAULT_USES_PINS: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == MODE_MUX) |=> (addr_out[ADDR_W-1:LOW_W] == $past(hi))); // R3
endmodule

// File: rtl/addr_capture_unit.sv
`timescale 1ns/1ps
module addr_capture_unit
  import acu_pkg::*;
#(
  parameter int UPPER_W = 8,
  localparam int ADDR_W = LOW_W + UPPER_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               adv,
  input  logic               oe_n,
  input  logic [LOW_W-1:0]   ad_bus,
  input  logic [UPPER_W-1:0] hi_pins,
  output logic [ADDR_W-1:0]  addr_out,
  output logic               addr_valid,
  output logic               mode_o,
  output logic [CFG_W-1:0]   cfg_word
);
  mode_e              mode;
  logic               en_rise;
  logic               upper_cap;
  logic [UPPER_W-1:0] upper_q;

  acu_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .word_q  (cfg_word),
    .mode    (mode),
    .en_rise (en_rise)
  );

  acu_upper_latch #(.W(UPPER_W)) u_upper (
    .clk (clk),
    .rst (rst),
    .clr (en_rise),
    .cap (upper_cap),
    .d   (ad_bus[UPPER_W-1:0]),
    .q   (upper_q)
  );

  acu_addr_assemble #(.UPPER_W(UPPER_W)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .oe_n       (oe_n),
    .mode       (mode),
    .ad         (ad_bus),
    .hi         (hi_pins),
    .upper_q    (upper_q),
    .upper_cap  (upper_cap),
    .addr_out   (addr_out),
    .addr_valid (addr_valid)
  );

  assign mode_o = (mode == MODE_ALLDATA);

  AST_ENABLED_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (adv && oe_n && mode_o) |=> (addr_valid && addr_out[LOW_W-1:0] == $past(ad_bus))); // R6
  AST_WRITE_KEEPS_OLD_DECODE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && adv && !mode_o) |=> addr_valid); // R10
endmodule

// File: tb/tb_addr_capture_unit.sv
`timescale 1ns/1ps
module tb_addr_capture_unit;
  localparam int UW = 8;
  localparam int AW = 16 + UW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          adv = 1'b0;
  logic          oe_n = 1'b1;
  logic [15:0]   ad_bus = '0;
  logic [UW-1:0] hi_pins = '0;
  logic [AW-1:0] addr_out;
  logic          addr_valid;
  logic          mode_o;
  logic [15:0]   cfg_word;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  int unsigned m_mode = 0;
  int unsigned m_upper = 0;
  int unsigned m_addr = 0;
  int unsigned m_valid = 0;
  int unsigned m_cfg = 0;

  always #4 clk = ~clk;

  addr_capture_unit #(.UPPER_W(UW)) dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .adv(adv), .oe_n(oe_n), .ad_bus(ad_bus), .hi_pins(hi_pins),
    .addr_out(addr_out), .addr_valid(addr_valid), .mode_o(mode_o),
    .cfg_word(cfg_word)
  );

  always @(posedge clk) begin
    int unsigned nxt_upper;
    nxt_upper = m_upper;
    if (rst) begin
      m_mode = 0; m_upper = 0; m_addr = 0; m_valid = 0; m_cfg = 0;
    end else begin
      m_valid = 0;
      if (adv) begin
        if (m_mode == 0) begin
          m_addr = hi_pins * 65536 + ad_bus; m_valid = 1;
        end else if (oe_n) begin
          m_addr = m_upper * 65536 + ad_bus; m_valid = 1;
        end else begin
          nxt_upper = ad_bus % (1 << UW);
        end
      end
      if (cfg_wr) begin
        if (cfg_wdata[4] && m_mode == 0) nxt_upper = 0;
        m_mode = cfg_wdata[4];
        m_cfg = cfg_wdata;
      end
      m_upper = nxt_upper;
    end
  end

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk({cur_req, " addr_out"}, addr_out, m_addr);
    chk({cur_req, " addr_valid"}, addr_valid, m_valid);
    chk({cur_req, " mode_o"}, mode_o, m_mode);
    chk({cur_req, " cfg_word"}, cfg_word, m_cfg);
  end

  task automatic step(logic a, logic o, logic [15:0] d, logic [UW-1:0] h,
                      logic w, logic [15:0] wd);
    @(negedge clk);
    #1;
    adv = a; oe_n = o; ad_bus = d; hi_pins = h; cfg_wr = w; cfg_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset addr", addr_out, 0);
    chk("R1 reset valid", addr_valid, 0);
    chk("R1 reset mode", mode_o, 0);
    @(negedge clk); #1; rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release", {addr_valid, mode_o}, 0);

    cur_req = "R3";
    step(1, 1, 16'h1234, 8'h5A, 0, 0);
    chk("R3 default oe high", addr_out, 24'h5A1234);
    step(1, 0, 16'hABCD, 8'h03, 0, 0);
    chk("R3 default oe low", addr_out, 24'h03ABCD);
    chk("R3 valid", addr_valid, 1);

    cur_req = "R9";
    step(0, 1, 16'hFFFF, 8'hEE, 0, 0);
    chk("R9 idle valid", addr_valid, 0);
    chk("R9 idle hold", addr_out, 24'h03ABCD);

    cur_req = "R2";
    step(0, 1, 0, 0, 1, 16'h00EF);
    chk("R2 other bits no mode", mode_o, 0);
    chk("R2 word stored", cfg_word, 16'h00EF);
    step(0, 1, 0, 0, 1, 16'h0010);
    chk("R2 enable", mode_o, 1);

    cur_req = "R4";
    step(1, 1, 16'h4444, 8'hFF, 0, 0);
    chk("R4 upper zero after enable", addr_out, 24'h004444);

    cur_req = "R5";
    step(1, 0, 16'h0077, 8'h00, 0, 0);
    chk("R5 upper phase no valid", addr_valid, 0);
    chk("R5 upper phase addr hold", addr_out, 24'h004444);

    cur_req = "R6";
    step(1, 1, 16'h1111, 8'h00, 0, 0);
    chk("R6 assembled", addr_out, 24'h771111);
    chk("R6 valid", addr_valid, 1);

    cur_req = "R7";
    step(0, 1, 0, 8'h42, 0, 0);
    step(1, 1, 16'h2222, 8'h33, 0, 0);
    chk("R7 persist pins ignored", addr_out, 24'h772222);

    cur_req = "R11";
    step(0, 1, 0, 0, 1, 16'h0010);
    step(1, 1, 16'h0005, 8'h12, 0, 0);
    chk("R11 re-enable keeps upper", addr_out, 24'h770005);

    cur_req = "R10";
    step(1, 0, 16'h0099, 8'h21, 1, 16'h0000);
    chk("R10 old mode decode no valid", addr_valid, 0);
    chk("R10 mode cleared", mode_o, 0);

    cur_req = "R8";
    step(1, 1, 16'h0100, 8'h21, 0, 0);
    chk("R8 pins again", addr_out, 24'h210100);

    cur_req = "R4";
    step(0, 1, 0, 0, 1, 16'h0010);
    step(1, 1, 16'h0006, 8'h55, 0, 0);
    chk("R4 zero after held 99", addr_out, 24'h000006);

    cur_req = "R10";
    step(1, 1, 16'h0008, 8'h66, 1, 16'h0000);
    chk("R10 write with strobe uses enabled decode", addr_out, 24'h000008);

    cur_req = "R1";
    step(1, 1, 16'h3333, 8'h44, 0, 0);
    @(negedge clk); #1; rst = 1'b1; adv = 0;
    @(posedge clk); #1;
    chk("R1 mid reset addr", addr_out, 0);
    chk("R1 mid reset mode", mode_o, 0);
    @(negedge clk); #1; rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule